// File: doc/BRIEF.md
# Peripheral Bus Command Responder

This block sits behind the host-side controller of a desktop peripheral bus. Command packets reach it as a byte stream. The block answers the bus-wide commands itself and sends every other command to one of two built-in device personalities: a keyboard and a pointer. It then builds the reply bytes. Each personality keeps a 4-bit bus address that software can move and an 8-bit handler ID. Only the keyboard's handler ID can be written.

The block also produces unsolicited reports. A key event becomes a four-byte keyboard report. A pointer event with signed X and Y deltas and two button levels becomes a four-byte motion report. In a motion report each delta is limited to a 7-bit range and a button is carried in bit 7. Only one reply or report is in flight at any time, and both streams use a valid/ready handshake.

A command packet holds at least one byte. Byte 0 is the command byte: bits [7:4] are the target address, bits [3:2] are the operation and bits [1:0] are the register. Bytes 1 and 2 are optional operands. Any byte after byte 2 is ignored.

Top module: `periph_cmd_resp`

## Requirements
- R1: `in_ready` is high exactly when no reply is pending. A reply is presented byte 0 first. `out_len` holds its byte count (1 to 4) for the whole reply and `out_last` marks the final byte. While `out_ready` is low, `out_data` and `out_len` hold their values.
- R2: A command byte of 0x00 (bus reset), or any command byte whose low nibble is 0x1 (flush), is answered with 0x00 0x00. No device address or handler changes.
- R3: A command for any other operation whose address matches neither device is answered with the single byte 0x02.
- R4: After reset the keyboard has address 2 and handler 0x02, and the pointer has address 3 and handler 0x01. A talk to register 3 (bits [3:0] = 0xF) returns 0x00, the handler, then {0000, address}.
- R5: A listen to register 3 (bits [3:0] = 0xB) with byte 2 equal to 0xFF returns 0x00 and changes nothing.
- R6: A listen to register 3 with byte 2 equal to 0xFE, 0xFD or 0x00 returns 0x00. It sets the device address to bits [3:0] of byte 1 and leaves the handler unchanged. Operand bytes missing from a short packet count as 0x00.
- R7: A listen to register 3 with any other byte 2 returns 0x00 and moves the address as in R6. On the keyboard, byte 2 also becomes the handler ID. The pointer handler never changes.
- R8: A listen to register 2 (0xA) returns 0x00 with no other effect. A talk to register 1 (0xD) returns 0x00. A keyboard talk to register 2 (0xE) returns 0x00 0x00 0x07.
- R9: Operations 00 and 01 (other than those in R2), listens to registers 0 and 1, talks to register 0 and a pointer talk to register 2 produce no reply and change no state.
- R10: An accepted key event produces the report 0x40, {keyboard address, 0xC}, {release, code[6:0]}, 0xFF.
- R11: An accepted pointer event produces the report 0x40, {pointer address, 0xC}, {left, dy7}, {right, dx7}. Each dN7 is the delta limited to the range -63 to +63, in 7-bit two's complement.
- R12: A report is accepted only when no reply is pending, no command packet is open and `in_valid` is low. When both events are offered together, the key event goes first.
- R13: When both devices hold the same address, the keyboard answers and the pointer is shadowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte valid |
| in_ready | output | 1 | Command byte accepted |
| in_data | input | 8 | Command byte |
| in_first | input | 1 | First byte of a packet |
| in_last | input | 1 | Last byte of a packet |
| out_valid | output | 1 | Reply byte valid |
| out_ready | input | 1 | Reply byte consumed |
| out_data | output | 8 | Reply byte |
| out_last | output | 1 | Final reply byte |
| out_len | output | 3 | Reply length in bytes |
| key_valid | input | 1 | Key event offered |
| key_ready | output | 1 | Key event accepted |
| key_code | input | 7 | Key code |
| key_release | input | 1 | Key released flag |
| ptr_valid | input | 1 | Pointer event offered |
| ptr_ready | output | 1 | Pointer event accepted |
| ptr_dx | input | DELTA_W | Signed X delta |
| ptr_dy | input | DELTA_W | Signed Y delta |
| ptr_left | input | 1 | Left button |
| ptr_right | input | 1 | Right button |

## Verification
The bench builds the block with its default parameters: addresses 2 and 3, handlers 0x02 and 0x01, 10-bit deltas and a limit of 63. With 10-bit deltas, random values from -512 to +511 reach both clamp edges as well as the pass-through range. Because the addresses can be moved, random listens drive the devices onto shared addresses, onto address 0 and onto unknown addresses. This brings the shadowing and not-present paths within reach as well as the directed cases.

// File: rtl/periph_cmd_resp.sv
module periph_cmd_resp #(
  parameter logic [3:0] KBD_ADDR_INIT    = 4'd2,
  parameter logic [3:0] PTR_ADDR_INIT    = 4'd3,
  parameter logic [7:0] KBD_HANDLER_INIT = 8'h02,
  parameter logic [7:0] PTR_HANDLER_INIT = 8'h01,
  parameter int         DELTA_W          = 10,
  parameter int         DELTA_LIM        = 63
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [7:0]                in_data,
  input  logic                      in_first,
  input  logic                      in_last,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [7:0]                out_data,
  output logic                      out_last,
  output logic [2:0]                out_len,
  input  logic                      key_valid,
  output logic                      key_ready,
  input  logic [6:0]                key_code,
  input  logic                      key_release,
  input  logic                      ptr_valid,
  output logic                      ptr_ready,
  input  logic signed [DELTA_W-1:0] ptr_dx,
  input  logic signed [DELTA_W-1:0] ptr_dy,
  input  logic                      ptr_left,
  input  logic                      ptr_right
);

  localparam logic signed [DELTA_W-1:0] LIM_P = DELTA_W'(DELTA_LIM);
  localparam logic signed [DELTA_W-1:0] LIM_N = -LIM_P;
  localparam logic [7:0] RPT_HDR = 8'h40;
  localparam logic [1:0] OP_LISTEN = 2'b10;
  localparam logic [1:0] OP_TALK   = 2'b11;

  logic       busy;
  logic [1:0] ridx;
  logic [2:0] rlen;
  logic [7:0] rbuf [4];

  logic [1:0] cnt;
  logic [7:0] cb, d1, d2;
  logic [3:0] kaddr, paddr;
  logic [7:0] khnd;

  logic       open_pkt, in_acc, done;
  logic [1:0] pos;
  logic [7:0] c_cmd, c_d1, c_d2;

  logic       k_hit, p_hit;
  logic [3:0] dev_addr;
  logic [7:0] dev_hnd;
  logic [2:0] n_len;
  logic [7:0] n_b [4];
  logic [3:0] n_kaddr, n_paddr;
  logic [7:0] n_khnd;

  assign in_ready  = !busy;
  assign out_valid = busy;
  assign out_data  = rbuf[ridx];
  assign out_len   = rlen;
  assign out_last  = busy && ({1'b0, ridx} == rlen - 3'd1);

  assign open_pkt  = cnt != 2'd0;
  assign key_ready = !busy && !open_pkt && !in_valid;
  assign ptr_ready = key_ready && !key_valid;

  assign in_acc = in_valid && in_ready && (in_first || open_pkt);
  assign done   = in_acc && in_last;
  assign pos    = in_first ? 2'd0 : cnt;
  assign c_cmd  = in_first ? in_data : cb;
  assign c_d1   = (pos == 2'd1) ? in_data : ((pos >= 2'd2) ? d1 : 8'h00);
  assign c_d2   = (pos == 2'd2) ? in_data : ((pos == 2'd3) ? d2 : 8'h00);

  function automatic logic [6:0] clamp7(input logic signed [DELTA_W-1:0] v);
    if (v > LIM_P)      clamp7 = LIM_P[6:0];
    else if (v < LIM_N) clamp7 = LIM_N[6:0];
    else                clamp7 = v[6:0];
  endfunction

  assign k_hit    = c_cmd[7:4] == kaddr;
  assign p_hit    = !k_hit && (c_cmd[7:4] == paddr);
  assign dev_addr = k_hit ? kaddr : paddr;
  assign dev_hnd  = k_hit ? khnd : PTR_HANDLER_INIT;

  always_comb begin
    n_len   = 3'd0;
    n_kaddr = kaddr;
    n_paddr = paddr;
    n_khnd  = khnd;
    for (int i = 0; i < 4; i++) n_b[i] = 8'h00;
    if (c_cmd == 8'h00 || c_cmd[3:0] == 4'h1) begin
      n_len = 3'd2;
    end else if (!k_hit && !p_hit) begin
      n_len  = 3'd1;
      n_b[0] = 8'h02;
    end else if (c_cmd[3:2] == OP_LISTEN) begin
      if (c_cmd[1]) n_len = 3'd1;
      if (c_cmd[1:0] == 2'b11 && c_d2 != 8'hFF) begin
        if (k_hit) n_kaddr = c_d1[3:0];
        else       n_paddr = c_d1[3:0];
        if (k_hit && !(c_d2 inside {8'hFE, 8'hFD, 8'h00})) n_khnd = c_d2;
      end
    end else if (c_cmd[3:2] == OP_TALK) begin
      case (c_cmd[1:0])
        2'd1: n_len = 3'd1;
        2'd2: if (k_hit) begin
          n_len  = 3'd3;
          n_b[2] = 8'h07;
        end
        2'd3: begin
          n_len  = 3'd3;
          n_b[1] = dev_hnd;
          n_b[2] = {4'h0, dev_addr};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ridx  <= 2'd0;
      rlen  <= 3'd0;
      for (int i = 0; i < 4; i++) rbuf[i] <= 8'h00;
      cnt   <= 2'd0;
      cb    <= 8'h00;
      d1    <= 8'h00;
      d2    <= 8'h00;
      kaddr <= KBD_ADDR_INIT;
      paddr <= PTR_ADDR_INIT;
      khnd  <= KBD_HANDLER_INIT;
    end else begin
      if (in_acc) begin
        if (in_first) begin
          cb  <= in_data;
          cnt <= 2'd1;
        end else begin
          if (cnt == 2'd1) d1 <= in_data;
          if (cnt == 2'd2) d2 <= in_data;
          if (cnt != 2'd3) cnt <= cnt + 2'd1;
        end
        if (in_last) cnt <= 2'd0;
      end
      if (done) begin
        kaddr <= n_kaddr;
        paddr <= n_paddr;
        khnd  <= n_khnd;
      end
      if (busy) begin
        if (out_ready) begin
          if (out_last) busy <= 1'b0;
          else          ridx <= ridx + 2'd1;
        end
      end else if (done && n_len != 3'd0) begin
        busy <= 1'b1;
        ridx <= 2'd0;
        rlen <= n_len;
        for (int i = 0; i < 4; i++) rbuf[i] <= n_b[i];
      end else if (key_valid && key_ready) begin
        busy    <= 1'b1;
        ridx    <= 2'd0;
        rlen    <= 3'd4;
        rbuf[0] <= RPT_HDR;
        rbuf[1] <= {kaddr, 4'hC};
        rbuf[2] <= {key_release, key_code};
        rbuf[3] <= 8'hFF;
      end else if (ptr_valid && ptr_ready) begin
        busy    <= 1'b1;
        ridx    <= 2'd0;
        rlen    <= 3'd4;
        rbuf[0] <= RPT_HDR;
        rbuf[1] <= {paddr, 4'hC};
        rbuf[2] <= {ptr_left, clamp7(ptr_dy)};
        rbuf[3] <= {ptr_right, clamp7(ptr_dx)};
      end
    end
  end

endmodule

// File: rtl/periph_cmd_resp_chk.sv
module periph_cmd_resp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       in_first,
  input logic       in_last,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic [2:0] out_len,
  input logic       key_valid,
  input logic       key_ready,
  input logic       ptr_valid,
  input logic       ptr_ready
);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_len));

  p_len_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len >= 3'd1 && out_len <= 3'd4));

  p_bus_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_first && in_last && in_data == 8'h00
    |=> out_valid && out_len == 3'd2 && out_data == 8'h00);

  p_key_report_r10: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid && key_ready |=> out_valid && out_len == 3'd4 && out_data == 8'h40);

  p_ptr_report_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_valid && ptr_ready |=> out_valid && out_len == 3'd4 && out_data == 8'h40);

  p_key_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_valid && ptr_ready |-> !key_valid);

  p_cmd_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !key_ready && !ptr_ready);

endmodule

bind periph_cmd_resp periph_cmd_resp_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .in_first(in_first), .in_last(in_last),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_len(out_len), .key_valid(key_valid), .key_ready(key_ready),
  .ptr_valid(ptr_valid), .ptr_ready(ptr_ready)
);

// File: tb/test_periph_cmd_resp.sv
module test_periph_cmd_resp;
  localparam int DW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_last;
  logic out_ready = 1'b0;
  logic [7:0] out_data;
  logic [2:0] out_len;
  logic key_valid = 1'b0, key_release = 1'b0, key_ready;
  logic [6:0] key_code = 7'h00;
  logic ptr_valid = 1'b0, ptr_left = 1'b0, ptr_right = 1'b0, ptr_ready;
  logic signed [DW-1:0] ptr_dx = '0, ptr_dy = '0;

  always #2.5 clk = ~clk;

  periph_cmd_resp i_periph_cmd_resp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_first(in_first), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_len(out_len),
    .key_valid(key_valid), .key_ready(key_ready), .key_code(key_code),
    .key_release(key_release),
    .ptr_valid(ptr_valid), .ptr_ready(ptr_ready), .ptr_dx(ptr_dx),
    .ptr_dy(ptr_dy), .ptr_left(ptr_left), .ptr_right(ptr_right)
  );

  int total = 0, bad = 0;
  logic [3:0] mk = 4'd2, mp = 4'd3;
  logic [7:0] mh = 8'h02;
  logic [7:0] em [4];
  int elen;
  logic [7:0] got [4];
  int got_n;
  int got_len;

  task automatic check(input string req, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_exp();
    for (int i = 0; i < 4; i++) em[i] = 8'h00;
    elen = 0;
  endtask

  task automatic model_cmd(input logic [7:0] c, input logic [7:0] a, input logic [7:0] b);
    logic kh, ph;
    clr_exp();
    kh = (c[7:4] == mk);
    ph = !kh && (c[7:4] == mp);
    if (c == 8'h00 || c[3:0] == 4'h1) elen = 2;
    else if (!kh && !ph) begin elen = 1; em[0] = 8'h02; end
    else begin
      case (c[3:0])
        4'hA: elen = 1;
        4'hB: begin
          elen = 1;
          if (b != 8'hFF) begin
            if (kh) mk = a[3:0]; else mp = a[3:0];
            if (kh && b != 8'hFE && b != 8'hFD && b != 8'h00) mh = b;
          end
        end
        4'hD: elen = 1;
        4'hE: if (kh) begin elen = 3; em[2] = 8'h07; end
        4'hF: begin
          elen = 3;
          em[1] = kh ? mh : 8'h01;
          em[2] = {4'h0, kh ? mk : mp};
        end
        default: ;
      endcase
    end
  endtask

  function automatic logic [6:0] clampv(input int v);
    int r;
    r = (v > 63) ? 63 : ((v < -63) ? -63 : v);
    return r[6:0];
  endfunction

  task automatic send_pkt(input int n, input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    logic [7:0] bb [3];
    bb[0] = b0; bb[1] = b1; bb[2] = b2;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = bb[i];
      in_first = (i == 0); in_last = (i == n - 1);
      @(negedge clk);
    end
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic collect();
    logic lst;
    got_n = 0; got_len = 0; lst = 1'b0;
    for (int i = 0; i < 4; i++) got[i] = 8'h00;
    for (int c = 0; c < 12; c++) begin
      if (out_valid) begin
        if (got_n < 4) got[got_n] = out_data;
        got_len = out_len; lst = out_last; got_n++;
        out_ready = 1'b1;
      end else out_ready = 1'b0;
      @(negedge clk);
      if (lst) break;
    end
    out_ready = 1'b0;
  endtask

  task automatic expect_reply(input string req);
    logic ok;
    collect();
    ok = (got_n == elen) && (elen == 0 || got_len == elen);
    for (int i = 0; i < 4; i++) if (i < elen && got[i] != em[i]) ok = 1'b0;
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual n=%0d len=%0d %h %h %h %h expected n=%0d %h %h %h %h",
               req, got_n, got_len, got[0], got[1], got[2], got[3],
               elen, em[0], em[1], em[2], em[3]);
    end
  endtask

  task automatic cmd(input string req, input int n, input logic [7:0] c,
                     input logic [7:0] a, input logic [7:0] b);
    model_cmd(c, (n > 1) ? a : 8'h00, (n > 2) ? b : 8'h00);
    send_pkt(n, c, a, b);
    expect_reply(req);
  endtask

  task automatic key_evt(input string req, input logic [6:0] code, input logic rel);
    key_valid = 1'b1; key_code = code; key_release = rel;
    @(negedge clk);
    key_valid = 1'b0;
    clr_exp(); elen = 4;
    em[0] = 8'h40; em[1] = {mk, 4'hC}; em[2] = {rel, code}; em[3] = 8'hFF;
    expect_reply(req);
  endtask

  task automatic ptr_evt(input string req, input int dx, input int dy, input logic l, input logic r);
    ptr_valid = 1'b1; ptr_dx = DW'(dx); ptr_dy = DW'(dy); ptr_left = l; ptr_right = r;
    @(negedge clk);
    ptr_valid = 1'b0;
    clr_exp(); elen = 4;
    em[0] = 8'h40; em[1] = {mp, 4'hC}; em[2] = {l, clampv(dy)}; em[3] = {r, clampv(dx)};
    expect_reply(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] hold;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset ready", in_ready === 1'b1, in_ready, 1);
    check("R1 reset idle", out_valid === 1'b0, out_valid, 0);

    cmd("R4 kbd defaults", 1, 8'h2F, 0, 0);
    cmd("R4 ptr defaults", 1, 8'h3F, 0, 0);
    cmd("R2 bus reset", 1, 8'h00, 0, 0);
    cmd("R2 flush", 1, 8'h51, 0, 0);
    cmd("R2 state kept", 1, 8'h2F, 0, 0);
    cmd("R3 not present", 1, 8'h9C, 0, 0);
    cmd("R5 self test", 3, 8'h2B, 8'h05, 8'hFF);
    cmd("R5 unchanged", 1, 8'h2F, 0, 0);
    cmd("R6 move kbd", 3, 8'h2B, 8'h07, 8'hFE);
    cmd("R6 kbd at 7", 1, 8'h7F, 0, 0);
    cmd("R6 short pkt", 2, 8'h7B, 8'h02, 0);
    cmd("R6 kbd at 2", 1, 8'h2F, 0, 0);
    cmd("R7 ptr move", 3, 8'h3B, 8'h0A, 8'h44);
    cmd("R7 ptr handler kept", 1, 8'hAF, 0, 0);
    cmd("R7 kbd handler", 3, 8'h2B, 8'h02, 8'h55);
    cmd("R7 kbd handler read", 1, 8'h2F, 0, 0);
    cmd("R8 listen reg2", 2, 8'h2A, 8'h12, 0);
    cmd("R8 talk reg1", 1, 8'h2D, 0, 0);
    cmd("R8 talk reg2", 1, 8'h2E, 0, 0);
    cmd("R9 talk reg0", 1, 8'h2C, 0, 0);
    cmd("R9 ptr talk reg2", 1, 8'hAE, 0, 0);
    cmd("R9 listen reg0", 2, 8'h28, 8'h33, 0);
    cmd("R9 op01", 1, 8'h24, 0, 0);
    cmd("R9 state kept", 1, 8'h2F, 0, 0);
    cmd("R13 ptr onto 2", 3, 8'hAB, 8'h02, 8'hFE);
    cmd("R13 kbd answers", 1, 8'h2F, 0, 0);
    cmd("R13 kbd away", 3, 8'h2B, 8'h05, 8'hFD);
    cmd("R13 ptr visible", 1, 8'h2F, 0, 0);
    cmd("R13 ptr back", 3, 8'h2B, 8'h03, 8'h00);
    cmd("R13 kbd back", 3, 8'h5B, 8'h02, 8'hFE);

    key_evt("R10 key release", 7'h31, 1'b1);
    key_evt("R10 key press", 7'h05, 1'b0);
    ptr_evt("R11 clamp both", 200, -300, 1'b1, 1'b0);
    ptr_evt("R11 small", -5, 5, 1'b0, 1'b1);
    ptr_evt("R11 edges", 63, -63, 1'b1, 1'b1);

    model_cmd(8'h2F, 0, 0);
    send_pkt(1, 8'h2F, 0, 0);
    hold = out_data;
    repeat (3) @(negedge clk);
    check("R1 hold valid", out_valid === 1'b1, out_valid, 1);
    check("R1 hold data", out_data === hold, out_data, hold);
    check("R1 hold len", out_len === 3'd3, out_len, 3);
    check("R1 busy not ready", in_ready === 1'b0, in_ready, 0);
    expect_reply("R1 drained reply");

    key_valid = 1'b1; ptr_valid = 1'b1; key_code = 7'h11; key_release = 1'b0;
    #1;
    check("R12 key ready", key_ready === 1'b1, key_ready, 1);
    check("R12 ptr blocked", ptr_ready === 1'b0, ptr_ready, 0);
    @(negedge clk);
    key_valid = 1'b0; ptr_valid = 1'b0;
    clr_exp(); elen = 4;
    em[0] = 8'h40; em[1] = {mk, 4'hC}; em[2] = 8'h11; em[3] = 8'hFF;
    expect_reply("R12 key went first");

    in_valid = 1'b1; in_data = 8'h2F; in_first = 1'b1; in_last = 1'b0;
    key_valid = 1'b1;
    #1;
    check("R12 in_valid blocks", key_ready === 1'b0, key_ready, 0);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
    #1;
    check("R12 open pkt blocks", key_ready === 1'b0, key_ready, 0);
    @(negedge clk);
    key_valid = 1'b0;
    model_cmd(8'h2F, 0, 0);
    in_valid = 1'b1; in_data = 8'h00; in_last = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    expect_reply("R12 packet completes");

    for (int it = 0; it < 250; it++) begin
      int k;
      logic [3:0] ad;
      k = $urandom_range(0, 9);
      if (k == 0) key_evt("R10 random key", 7'($urandom), 1'($urandom));
      else if (k == 1)
        ptr_evt("R11 random ptr", int'($urandom_range(0, 1023)) - 512,
                int'($urandom_range(0, 1023)) - 512, 1'($urandom), 1'($urandom));
      else begin
        case ($urandom_range(0, 4))
          0: ad = mk;
          1: ad = mp;
          2: ad = 4'h0;
          default: ad = 4'($urandom);
        endcase
        cmd("R2-R9,R13 random cmd", $urandom_range(1, 3), {ad, 4'($urandom)},
            8'($urandom), ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom));
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule